// File: doc/BRIEF.md
# I2C SCL Divider Parameter Search Engine

This block works out the two clock-divider fields of an I2C bus controller in hardware. A one-cycle start pulse captures a 32-bit peripheral clock rate and a 32-bit target SCL rate, both in Hz. The engine then walks a fixed search:

- It first picks a prescaler select that brings the internal clock under a 20 MHz ceiling.
- It then computes a rounded edge-delay term, which models 285 ns of fall time, rise time and internal delay.
- Finally it scans the SCL generation count until the resulting bus rate no longer exceeds the target.

Every quotient comes from one shared sequential divider, so one search spans many cycles. When the search ends, the engine gives a one-cycle done pulse, the two fields, an 8-bit packed value and an error flag. These stay in place until the next search finishes.

Top module: `scl_div_search`

## Requirements
- R1: The prescaler select is tried from 0 up to 3. The internal clock is the peripheral clock divided by (1 + select), in integer division. The first select whose internal clock is strictly below 20 000 000 is kept.
- R2: If no select from 0 to 3 gives an internal clock below 20 000 000, the search ends with err_o = 1, and sel_o, cnt_o and packed_o are all 0.
- R3: The edge term is ((internal + 500000) / 1000000 * 285 + 500) / 1000, computed in unsigned integer arithmetic.
- R4: The SCL rate for count c is internal / (20 + 8*c + edge term). The count is tried from 0 up to 63. The first c whose rate is at or below the target is kept, and err_o = 0.
- R5: If no count from 0 to 63 meets the target, the search ends with err_o = 1, and sel_o, cnt_o and packed_o are all 0.
- R6: packed_o holds the count in bits [7:2] and the select in bits [1:0], which gives (count << 2) | select.
- R7: done_o is high for exactly one cycle when a search ends, and it is low otherwise.
- R8: A start pulse that arrives while a search is running is ignored. The result is that of the search already under way.
- R9: An accepted start clears err_o at the next clock edge. All outputs hold their values until the next search ends.
- R10: After reset, done_o, err_o, sel_o, cnt_o and packed_o are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse; it is only taken when the engine is idle |
| pclk_hz_i | input | 32 | Peripheral clock rate in Hz, captured at start |
| scl_hz_i | input | 32 | Target SCL rate in Hz, captured at start |
| done_o | output | 1 | One-cycle pulse at the end of a search |
| err_o | output | 1 | The last search found no legal setting |
| sel_o | output | 2 | Chosen prescaler select |
| cnt_o | output | 6 | Chosen SCL generation count |
| packed_o | output | 8 | Packed value: count in [7:2], select in [1:0] |

## Verification
The assertions check four rules on every cycle:
- done_o never lasts longer than one cycle.
- err_o only rises together with done_o, and an error result always carries zero fields.
- The packed value changes only on a done cycle.
- A start taken while idle clears the error flag, and a start seen while busy does not end the search.

Whether the chosen select and count are the right ones depends on the arithmetic of the search: the strict 20 MHz boundary, the rounding of the edge term, a target met exactly, and the last count 63. Only the bench's vectors, each worked out by hand, can show these.

// File: rtl/scl_div_pkg.sv
package scl_div_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEL,
    ST_EDGE_MHZ,
    ST_EDGE_NS,
    ST_CNT
  } srch_state_e;
endpackage

// File: rtl/scl_div_seqdiv.sv
module scl_div_seqdiv #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         go_i,
  input  logic [W-1:0] num_i,
  input  logic [W-1:0] den_i,
  output logic         done_o,
  output logic [W-1:0] quo_o
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  rem_q, quo_q;
  logic [CW-1:0] left_q;
  logic          run_q, done_q;
  logic [W:0]    trial;
  logic [W:0]    diff;
  logic          fits;

  assign trial = {rem_q, quo_q[W-1]};
  assign diff  = trial - {1'b0, den_i};
  assign fits  = trial >= {1'b0, den_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      quo_q  <= '0;
      left_q <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (go_i) begin
        rem_q  <= '0;
        quo_q  <= num_i;
        left_q <= CW'(W);
        run_q  <= 1'b1;
      end else if (run_q) begin
        rem_q  <= fits ? diff[W-1:0] : trial[W-1:0];
        quo_q  <= {quo_q[W-2:0], fits};
        left_q <= left_q - 1'b1;
        if (left_q == CW'(1)) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done_o = done_q;
  assign quo_o  = quo_q;
endmodule

// File: rtl/scl_div_ctrl.sv
module scl_div_ctrl
  import scl_div_pkg::*;
#(
  parameter int W       = 32,
  parameter int SEL_W   = 2,
  parameter int CNT_W   = 6,
  parameter int ICK_MAX = 20_000_000,
  parameter int EDGE_NS = 285,
  parameter int BASE    = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [W-1:0]     pclk_i,
  input  logic [W-1:0]     tgt_i,
  input  logic             div_done_i,
  input  logic [W-1:0]     div_quo_i,
  output logic             div_go_o,
  output logic [W-1:0]     div_num_o,
  output logic [W-1:0]     div_den_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o,
  output logic [SEL_W-1:0] sel_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [SEL_W-1:0] SEL_LAST = '1;
  localparam logic [CNT_W-1:0] CNT_LAST = '1;
  localparam logic [W-1:0] LIM   = W'(ICK_MAX);
  localparam logic [W-1:0] HALF  = W'(500_000);
  localparam logic [W-1:0] MHZ   = W'(1_000_000);
  localparam logic [W-1:0] NSK   = W'(EDGE_NS);
  localparam logic [W-1:0] R500  = W'(500);
  localparam logic [W-1:0] K1000 = W'(1000);
  localparam logic [W-1:0] BSE   = W'(BASE);

  srch_state_e      st_q;
  logic [W-1:0]     pclk_q, tgt_q, ick_q, edge_q;
  logic [SEL_W-1:0] sel_q, rsel_q;
  logic [CNT_W-1:0] cnt_q, rcnt_q;
  logic             go_q, done_q, err_q;
  logic [W-1:0]     num_q, den_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      pclk_q <= '0;
      tgt_q  <= '0;
      ick_q  <= '0;
      edge_q <= '0;
      sel_q  <= '0;
      cnt_q  <= '0;
      rsel_q <= '0;
      rcnt_q <= '0;
      go_q   <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      num_q  <= '0;
      den_q  <= '0;
    end else begin
      go_q   <= 1'b0;
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          pclk_q <= pclk_i;
          tgt_q  <= tgt_i;
          err_q  <= 1'b0;
          sel_q  <= '0;
          num_q  <= pclk_i;
          den_q  <= W'(1);
          go_q   <= 1'b1;
          st_q   <= ST_SEL;
        end
        ST_SEL: if (div_done_i) begin
          if (div_quo_i < LIM) begin
            ick_q <= div_quo_i;
            num_q <= div_quo_i + HALF;
            den_q <= MHZ;
            go_q  <= 1'b1;
            st_q  <= ST_EDGE_MHZ;
          end else if (sel_q == SEL_LAST) begin
            err_q  <= 1'b1;
            rsel_q <= '0;
            rcnt_q <= '0;
            done_q <= 1'b1;
            st_q   <= ST_IDLE;
          end else begin
            sel_q <= sel_q + 1'b1;
            num_q <= pclk_q;
            den_q <= W'(sel_q) + W'(2);
            go_q  <= 1'b1;
          end
        end
        ST_EDGE_MHZ: if (div_done_i) begin
          num_q <= div_quo_i * NSK + R500;
          den_q <= K1000;
          go_q  <= 1'b1;
          st_q  <= ST_EDGE_NS;
        end
        ST_EDGE_NS: if (div_done_i) begin
          edge_q <= div_quo_i;
          cnt_q  <= '0;
          num_q  <= ick_q;
          den_q  <= BSE + div_quo_i;
          go_q   <= 1'b1;
          st_q   <= ST_CNT;
        end
        ST_CNT: if (div_done_i) begin
          if (div_quo_i <= tgt_q) begin
            rsel_q <= sel_q;
            rcnt_q <= cnt_q;
            done_q <= 1'b1;
            st_q   <= ST_IDLE;
          end else if (cnt_q == CNT_LAST) begin
            err_q  <= 1'b1;
            rsel_q <= '0;
            rcnt_q <= '0;
            done_q <= 1'b1;
            st_q   <= ST_IDLE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
            num_q <= ick_q;
            den_q <= BSE + ((W'(cnt_q) + W'(1)) << 3) + edge_q;
            go_q  <= 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign div_go_o  = go_q;
  assign div_num_o = num_q;
  assign div_den_o = den_q;
  assign busy_o    = (st_q != ST_IDLE);
  assign done_o    = done_q;
  assign err_o     = err_q;
  assign sel_o     = rsel_q;
  assign cnt_o     = rcnt_q;
endmodule

// File: rtl/scl_div_search.sv
module scl_div_search #(
  parameter int W       = 32,
  parameter int SEL_W   = 2,
  parameter int CNT_W   = 6,
  parameter int ICK_MAX = 20_000_000,
  parameter int EDGE_NS = 285,
  parameter int BASE    = 20
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic [W-1:0]           pclk_hz_i,
  input  logic [W-1:0]           scl_hz_i,
  output logic                   done_o,
  output logic                   err_o,
  output logic [SEL_W-1:0]       sel_o,
  output logic [CNT_W-1:0]       cnt_o,
  output logic [SEL_W+CNT_W-1:0] packed_o
);
  logic         div_go, div_done, busy;
  logic [W-1:0] div_num, div_den, div_quo;

  scl_div_ctrl #(
    .W(W), .SEL_W(SEL_W), .CNT_W(CNT_W),
    .ICK_MAX(ICK_MAX), .EDGE_NS(EDGE_NS), .BASE(BASE)
  ) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .pclk_i     (pclk_hz_i),
    .tgt_i      (scl_hz_i),
    .div_done_i (div_done),
    .div_quo_i  (div_quo),
    .div_go_o   (div_go),
    .div_num_o  (div_num),
    .div_den_o  (div_den),
    .busy_o     (busy),
    .done_o     (done_o),
    .err_o      (err_o),
    .sel_o      (sel_o),
    .cnt_o      (cnt_o)
  );

  scl_div_seqdiv #(.W(W)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .go_i   (div_go),
    .num_i  (div_num),
    .den_i  (div_den),
    .done_o (div_done),
    .quo_o  (div_quo)
  );

  assign packed_o = {cnt_o, sel_o};
endmodule

// File: rtl/scl_div_search_chk.sv
module scl_div_search_chk #(
  parameter int SEL_W = 2,
  parameter int CNT_W = 6
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   start_i,
  input logic                   done_o,
  input logic                   err_o,
  input logic [SEL_W+CNT_W-1:0] packed_o,
  input logic                   busy
);
  assert_done_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_err_at_done_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> done_o);
  assert_err_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && err_o) |-> (packed_o == '0));
  assert_err_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy) |=> !err_o);
  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |=> (done_o || $stable(packed_o)));
  assert_ignore_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && busy) |=> (busy || done_o));
endmodule

bind scl_div_search scl_div_search_chk #(.SEL_W(SEL_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/tb_scl_div_search.sv
module tb_scl_div_search;
  typedef struct packed {
    logic [31:0] pclk;
    logic [31:0] tgt;
    logic        err;
    logic [7:0]  pk;
  } vec_t;

  // expected values worked out by hand from R1..R6
  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{32'd65_000_000,    32'd400_000,       1'b0, 8'h0B}, // R1 sel3, R3 edge 5, cnt2
    '{32'd10_000_000,    32'd100_000,       1'b0, 8'h28}, // sel0 cnt10
    '{32'd100_000_000,   32'd100_000,       1'b1, 8'h00}, // R2
    '{32'd10_000_000,    32'd10_000,        1'b1, 8'h00}, // R5
    '{32'd19_999_999,    32'd4_000_000_000, 1'b0, 8'h00}, // R1 just below ceiling
    '{32'd20_000_000,    32'd100_000,       1'b0, 8'h29}, // R1 strict: sel1
    '{32'd40_000_000,    32'd1_000_000,     1'b0, 8'h02}, // sel2 cnt0
    '{32'd79_999_999,    32'd1,             1'b1, 8'h00}, // R5 at sel3
    '{32'hFFFF_FFFF,     32'd400_000,       1'b1, 8'h00}, // R2 max clock
    '{32'd1_000_000,     32'd1_000_000,     1'b0, 8'h00}, // R3 edge 0
    '{32'd10_000_000,    32'd97_087,        1'b0, 8'h28}, // R4 exact hit
    '{32'd10_000_000,    32'd18_975,        1'b0, 8'hFC}  // R4 last count 63
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] pclk = '0, tgt = '0;
  logic        done, err;
  logic [1:0]  sel;
  logic [5:0]  cnt;
  logic [7:0]  pk;
  int          n_chk = 0, n_bad = 0;

  always #2ns clk = ~clk;

  scl_div_search dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .pclk_hz_i(pclk), .scl_hz_i(tgt),
    .done_o(done), .err_o(err), .sel_o(sel), .cnt_o(cnt), .packed_o(pk)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic kick(input logic [31:0] p, input logic [31:0] t);
    @(negedge clk);
    pclk = p; tgt = t; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    while (!done && n < 6000) begin
      @(negedge clk);
      n++;
    end
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL %s watchdog: no done actual=0 expected=1", req);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R10 done", 32'(done), 0);
    check("R10 err", 32'(err), 0);
    check("R10 packed", 32'(pk), 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      kick(VECS[i].pclk, VECS[i].tgt);
      wait_done("R4 table");
      check("R1/R2/R4/R5 err", 32'(err), 32'(VECS[i].err));
      check("R6 packed", 32'(pk), 32'(VECS[i].pk));
      check("R6 fields", 32'({cnt, sel}), 32'(VECS[i].pk));
      @(negedge clk);
      check("R7 done single cycle", 32'(done), 0);
    end

    // R9: hold after done, err clears on next accepted start
    kick(32'd10_000_000, 32'd18_974); // R5: one below last count
    wait_done("R5 limit");
    check("R5 err", 32'(err), 1);
    check("R5 packed", 32'(pk), 0);
    repeat (20) @(negedge clk);
    check("R9 err held", 32'(err), 1);
    @(negedge clk);
    pclk = 32'd65_000_000; tgt = 32'd400_000; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R9 err cleared", 32'(err), 0);
    check("R9 packed held", 32'(pk), 0);
    wait_done("R9 run");
    check("R9 result", 32'(pk), 32'h0B);
    repeat (30) @(negedge clk);
    check("R9 packed hold", 32'(pk), 32'h0B);

    // R8: second start mid-search ignored
    kick(32'd10_000_000, 32'd100_000);
    repeat (5) @(negedge clk);
    pclk = 32'd100_000_000; tgt = 32'd1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done("R8 run");
    check("R8 err", 32'(err), 0);
    check("R8 packed", 32'(pk), 32'h28);
    @(negedge clk);
    check("R7 no extra done", 32'(done), 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule